// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small processor subsystem between a running state and two reduced-power states, idle and sleep. It owns the registered enables that gate the core clock and the peripheral clocks, the power-down control of the main oscillator, and the output gate of the internal RC oscillator. It also owns the power and connect controls of the PLL, the flash standby request, and a pair of clear pulses for the CPU and USB clock dividers. Software requests a mode with a write-one strobe. The sequencer then enters the mode on its own and clears the request. It returns to running when an enabled interrupt line or the always-running RTC-domain interrupt fires, or on reset.

Idle stops only the core clock, so peripherals keep running and can raise the interrupt that ends idle. Sleep stops every derived clock, powers the main oscillator down, gates the RC oscillator output while keeping that oscillator powered, puts the flash in standby, turns the PLL off and disconnects it, and clears both clock dividers. Wake-up from sleep is staged. The RC oscillator output comes back first, and the core and peripheral clocks follow after a settle window. The PLL stays off until software turns it back on.

Top module: `lpm_seq`

## Requirements
- R1: After synchronous reset the block is in run (`lpm_state` = 0). The core and peripheral clocks are enabled, the main oscillator is powered, the RC output is enabled, and flash standby is off. The PLL is off and disconnected, and `mode_req` is 0.
- R2: A `mode_wr` strobe in run loads `mode_req` on the next edge: 2'b10 if `mode_wdata[1]` is set, otherwise 2'b01 if `mode_wdata[0]` is set. Sleep takes priority when both bits are set. Data 2'b00 leaves `mode_req` at 0 and the state at run.
- R3: One edge after `mode_req` becomes nonzero, the state changes to idle (1) or sleep (2) and `mode_req` returns to 0. Outside run, `mode_req` is always 0 and mode writes are ignored.
- R4: In idle (state 1), only the core clock enable is low. Peripheral clocks, main oscillator, RC output, flash and PLL are unchanged from run.
- R5: In sleep (state 2), the core and peripheral clock enables are low, `main_osc_pd` is high, the RC output enable is low while `rc_osc_pwr_en` stays high, `flash_standby` is high, and the PLL is off and disconnected.
- R6: `cpu_div_clr` and `usb_div_clr` are high together for exactly the first cycle in sleep and low at every other time.
- R7: A wake event is any `irq[i]` with `irq_mask[i]` set, or `rtc_irq`. An `irq` line whose mask bit is clear has no effect.
- R8: In idle, a wake event returns the state to run on the next edge, with the core clock enabled.
- R9: In sleep, a wake event moves the state to wake (3) on the next edge. There the RC output is enabled, the main oscillator is powered and flash standby is off, while the core and peripheral clocks stay gated. After `RC_SETTLE` cycles in wake, the state returns to run with both clocks enabled.
- R10: `pll_wr` in run sets PLL power from `pll_wdata[0]` and connect from `pll_wdata[0] & pll_wdata[1]`, so connect never holds without power. PLL writes outside run are ignored. After a sleep the PLL stays off until such a write.
- R11: A wake event in the cycle in which a mode is entered does not block entry. The mode is still entered, and the block leaves it one edge later even if the event has gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode request write strobe |
| mode_wdata | input | 2 | Bit 1 sleep request, bit 0 idle request |
| pll_wr | input | 1 | PLL control write strobe |
| pll_wdata | input | 2 | Bit 0 power, bit 1 connect |
| irq | input | N_IRQ | Interrupt request lines |
| irq_mask | input | N_IRQ | Per-line wake enable |
| rtc_irq | input | 1 | RTC-domain interrupt, always a wake source |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| main_osc_pd | output | 1 | Main oscillator power-down |
| rc_osc_pwr_en | output | 1 | RC oscillator power enable |
| rc_osc_out_en | output | 1 | RC oscillator output gate enable |
| pll_pwr_en | output | 1 | PLL power enable |
| pll_connect | output | 1 | PLL output connected to the clock tree |
| flash_standby | output | 1 | Flash standby request |
| cpu_div_clr | output | 1 | CPU clock divider clear pulse |
| usb_div_clr | output | 1 | USB clock divider clear pulse |
| mode_req | output | 2 | Pending mode request |
| lpm_state | output | 2 | 0 run, 1 idle, 2 sleep, 3 wake |

## Verification
The delicate overlap is a wake event that arrives in the same cycle as mode entry, the cycle in which `mode_req` is nonzero and the state is still run. The bench raises an enabled interrupt for that single cycle, for both idle and sleep. It then checks that the reduced-power state is still entered on the next edge and left on the edge after it, with the event already withdrawn. A second overlap, a mode or PLL write while not in run, is driven during idle and judged by `mode_req`, the state and the PLL outputs staying unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LPM_RUN   = 2'd0,
    LPM_IDLE  = 2'd1,
    LPM_SLEEP = 2'd2,
    LPM_WAKE  = 2'd3
  } lpm_state_e;

  typedef struct packed {
    logic core_en;
    logic periph_en;
    logic osc_pd;
    logic rc_out_en;
    logic flash_stby;
  } lpm_gate_t;

  function automatic lpm_gate_t gate_for(lpm_state_e s);
    lpm_gate_t g;
    g = '{core_en: 1'b1, periph_en: 1'b1, osc_pd: 1'b0,
          rc_out_en: 1'b1, flash_stby: 1'b0};
    case (s)
      LPM_IDLE:  g.core_en = 1'b0;
      LPM_SLEEP: g = '{core_en: 1'b0, periph_en: 1'b0, osc_pd: 1'b1,
                       rc_out_en: 1'b0, flash_stby: 1'b1};
      LPM_WAKE:  begin
        g.core_en   = 1'b0;
        g.periph_en = 1'b0;
      end
      default: ;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             rtc_irq,
  input  logic             entering,
  output logic             wake_now,
  output logic             wake_any
);
  logic [N_IRQ-1:0] qual;
  logic             wake_pend;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_qual
    assign qual[i] = irq[i] & irq_mask[i];
  end

  assign wake_now = (|qual) | rtc_irq;
  assign wake_any = wake_now | wake_pend;

  // Holds a wake event seen during the entry cycle for one cycle.
  always_ff @(posedge clk) begin
    if (rst) wake_pend <= 1'b0;
    else     wake_pend <= entering & wake_now;
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int RC_SETTLE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       wake_any,
  output lpm_state_e state,
  output lpm_state_e state_nxt,
  output logic       entering,
  output logic       sleep_entry,
  output logic [1:0] mode_req
);
  localparam int CW = (RC_SETTLE > 1) ? $clog2(RC_SETTLE) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(RC_SETTLE - 1);

  logic [CW-1:0] settle_cnt;

  assign entering    = (state == LPM_RUN) && (mode_req != 2'b00);
  assign sleep_entry = entering && mode_req[1];

  always_comb begin
    state_nxt = state;
    case (state)
      LPM_RUN:   if (mode_req[1]) state_nxt = LPM_SLEEP;
                 else if (mode_req[0]) state_nxt = LPM_IDLE;
      LPM_IDLE:  if (wake_any) state_nxt = LPM_RUN;
      LPM_SLEEP: if (wake_any) state_nxt = LPM_WAKE;
      LPM_WAKE:  if (settle_cnt == '0) state_nxt = LPM_RUN;
      default:   state_nxt = LPM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LPM_RUN;
      settle_cnt <= '0;
    end else begin
      state <= state_nxt;
      if (state == LPM_SLEEP && state_nxt == LPM_WAKE) settle_cnt <= CNT_LOAD;
      else if (state == LPM_WAKE && settle_cnt != '0)  settle_cnt <= settle_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_req <= 2'b00;
    end else if (state == LPM_RUN) begin
      if (entering)
        mode_req <= 2'b00;
      else if (mode_wr && mode_wdata != 2'b00)
        mode_req <= mode_wdata[1] ? 2'b10 : 2'b01;
    end
  end

  assert_req_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (state != LPM_RUN) |-> (mode_req == 2'b00));

  assert_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (state == LPM_RUN && mode_req != 2'b00) |=> (state != LPM_RUN));
endmodule

// File: rtl/lpm_pll_ctl.sv
module lpm_pll_ctl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lpm_state_e state,
  input  logic       entering,
  input  logic       sleep_entry,
  input  logic       pll_wr,
  input  logic [1:0] pll_wdata,
  output logic       pll_pwr,
  output logic       pll_conn
);
  always_ff @(posedge clk) begin
    if (rst || sleep_entry) begin
      pll_pwr  <= 1'b0;
      pll_conn <= 1'b0;
    end else if (pll_wr && state == LPM_RUN && !entering) begin
      pll_pwr  <= pll_wdata[0];
      pll_conn <= pll_wdata[0] & pll_wdata[1];
    end
  end

  assert_conn_needs_pwr_R10: assert property (@(posedge clk) disable iff (rst)
    pll_conn |-> pll_pwr);
endmodule

// File: rtl/lpm_out_reg.sv
module lpm_out_reg
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lpm_state_e state_nxt,
  input  logic       sleep_entry,
  output lpm_gate_t  gate,
  output logic       div_clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate    <= gate_for(LPM_RUN);
      div_clr <= 1'b0;
    end else begin
      gate    <= gate_for(state_nxt);
      div_clr <= sleep_entry;
    end
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int RC_SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             pll_wr,
  input  logic [1:0]       pll_wdata,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             rtc_irq,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             main_osc_pd,
  output logic             rc_osc_pwr_en,
  output logic             rc_osc_out_en,
  output logic             pll_pwr_en,
  output logic             pll_connect,
  output logic             flash_standby,
  output logic             cpu_div_clr,
  output logic             usb_div_clr,
  output logic [1:0]       mode_req,
  output logic [1:0]       lpm_state
);
  lpm_state_e state, state_nxt;
  logic       entering, sleep_entry, wake_now, wake_any, div_clr;
  lpm_gate_t  gate;

  lpm_wake_qual #(.N_IRQ(N_IRQ)) u_wake (
    .clk(clk), .rst(rst), .irq(irq), .irq_mask(irq_mask), .rtc_irq(rtc_irq),
    .entering(entering), .wake_now(wake_now), .wake_any(wake_any)
  );

  lpm_fsm #(.RC_SETTLE(RC_SETTLE)) u_fsm (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .wake_any(wake_any), .state(state), .state_nxt(state_nxt),
    .entering(entering), .sleep_entry(sleep_entry), .mode_req(mode_req)
  );

  lpm_pll_ctl u_pll (
    .clk(clk), .rst(rst), .state(state), .entering(entering),
    .sleep_entry(sleep_entry), .pll_wr(pll_wr), .pll_wdata(pll_wdata),
    .pll_pwr(pll_pwr_en), .pll_conn(pll_connect)
  );

  lpm_out_reg u_out (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .sleep_entry(sleep_entry),
    .gate(gate), .div_clr(div_clr)
  );

  assign core_clk_en   = gate.core_en;
  assign periph_clk_en = gate.periph_en;
  assign main_osc_pd   = gate.osc_pd;
  assign rc_osc_out_en = gate.rc_out_en;
  assign flash_standby = gate.flash_stby;
  assign rc_osc_pwr_en = 1'b1;
  assign cpu_div_clr   = div_clr;
  assign usb_div_clr   = div_clr;
  assign lpm_state     = state;

  assert_idle_gating_R4: assert property (@(posedge clk) disable iff (rst)
    (state == LPM_IDLE) |-> (!core_clk_en && periph_clk_en && !main_osc_pd
                             && rc_osc_out_en && !flash_standby));

  assert_sleep_gating_R5: assert property (@(posedge clk) disable iff (rst)
    (state == LPM_SLEEP) |-> (!core_clk_en && !periph_clk_en && main_osc_pd
                              && !rc_osc_out_en && flash_standby && !pll_pwr_en));

  assert_div_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_div_clr |-> (state == LPM_SLEEP && $past(state) == LPM_RUN));

  assert_idle_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state == LPM_IDLE && wake_now) |=> (state == LPM_RUN && core_clk_en));

  assert_wake_order_R9: assert property (@(posedge clk) disable iff (rst)
    (state == LPM_WAKE) |-> (rc_osc_out_en && !core_clk_en && !main_osc_pd));

  assert_entry_wake_R11: assert property (@(posedge clk) disable iff (rst)
    (entering && wake_now) |=> (state == LPM_IDLE || state == LPM_SLEEP));
endmodule

// File: tb/tb_lpm_seq.sv
module tb_lpm_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ      = 8;
  localparam int RC_SETTLE  = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             mode_wr, pll_wr, rtc_irq;
  logic [1:0]       mode_wdata, pll_wdata;
  logic [N_IRQ-1:0] irq, irq_mask;
  logic core_clk_en, periph_clk_en, main_osc_pd, rc_osc_pwr_en, rc_osc_out_en;
  logic pll_pwr_en, pll_connect, flash_standby, cpu_div_clr, usb_div_clr;
  logic [1:0] mode_req, lpm_state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_seq #(.N_IRQ(N_IRQ), .RC_SETTLE(RC_SETTLE)) dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .pll_wr(pll_wr), .pll_wdata(pll_wdata), .irq(irq), .irq_mask(irq_mask),
    .rtc_irq(rtc_irq), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .main_osc_pd(main_osc_pd), .rc_osc_pwr_en(rc_osc_pwr_en),
    .rc_osc_out_en(rc_osc_out_en), .pll_pwr_en(pll_pwr_en),
    .pll_connect(pll_connect), .flash_standby(flash_standby),
    .cpu_div_clr(cpu_div_clr), .usb_div_clr(usb_div_clr),
    .mode_req(mode_req), .lpm_state(lpm_state)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Packs {core, periph, osc_pd, rc_pwr, rc_out, flash, pll_pwr, pll_conn, div_clr x2}.
  function automatic int outs();
    return {core_clk_en, periph_clk_en, main_osc_pd, rc_osc_pwr_en, rc_osc_out_en,
            flash_standby, pll_pwr_en, pll_connect, cpu_div_clr, usb_div_clr};
  endfunction

  function automatic int exp_outs(bit core, bit per, bit pd, bit rco, bit fl,
                                  bit pp, bit pc, bit dc);
    return {core, per, pd, 1'b1, rco, fl, pp, pc, dc, dc};
  endfunction

  task automatic write_mode(logic [1:0] d);
    mode_wr = 1'b1; mode_wdata = d;
    step();
    mode_wr = 1'b0; mode_wdata = 2'b00;
  endtask

  task automatic write_pll(logic [1:0] d);
    pll_wr = 1'b1; pll_wdata = d;
    step();
    pll_wr = 1'b0; pll_wdata = 2'b00;
  endtask

  task automatic pulse_rtc();
    rtc_irq = 1'b1;
    step();
    rtc_irq = 1'b0;
  endtask

  task automatic enter_idle();
    write_mode(2'b01);
    chk("R2 idle req", mode_req, 1);
    step();
    chk("R3 idle entered", lpm_state, 1);
    chk("R3 req cleared", mode_req, 0);
  endtask

  task automatic wake_from_sleep(bit pp, bit pc);
    pulse_rtc();
    chk("R9 wake state", lpm_state, 3);
    chk("R9 rc first", outs(), exp_outs(0, 0, 0, 1, 0, pp, pc, 0));
    for (int k = 1; k < RC_SETTLE; k++) begin
      step();
      chk("R9 settle hold", lpm_state, 3);
    end
    step();
    chk("R9 run after settle", lpm_state, 0);
    chk("R9 clocks back", outs(), exp_outs(1, 1, 0, 1, 0, pp, pc, 0));
  endtask

  initial begin
    rst = 1'b1; mode_wr = 1'b0; mode_wdata = 2'b00; pll_wr = 1'b0;
    pll_wdata = 2'b00; irq = '0; irq_mask = '0; rtc_irq = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1 reset state", lpm_state, 0);
    chk("R1 reset outs", outs(), exp_outs(1, 1, 0, 1, 0, 0, 0, 0));
    chk("R1 reset req", mode_req, 0);

    // R10: all PLL write codes in run
    for (int d = 0; d < 4; d++) begin
      write_pll(d[1:0]);
      chk("R10 pll pwr", pll_pwr_en, d & 1);
      chk("R10 pll conn", pll_connect, (d == 3) ? 1 : 0);
    end

    // R2: write of 00 has no effect
    write_mode(2'b00);
    chk("R2 zero req", mode_req, 0);
    step();
    chk("R2 zero stays run", lpm_state, 0);

    // R7/R8: every irq line, masked then unmasked, in idle
    for (int i = 0; i < N_IRQ; i++) begin
      enter_idle();
      chk("R4 idle outs", outs(), exp_outs(1'b0, 1, 0, 1, 0, 1, 1, 0));
      irq_mask = '1; irq_mask[i] = 1'b0; irq = '0; irq[i] = 1'b1;
      step();
      irq = '0;
      chk("R7 masked line ignored", lpm_state, 1);
      irq_mask = '0; irq_mask[i] = 1'b1; irq[i] = 1'b1;
      step();
      irq = '0;
      chk("R8 idle exit", lpm_state, 0);
      chk("R8 core on", core_clk_en, 1);
    end
    irq_mask = '0;

    // R3: mode and PLL writes ignored outside run
    enter_idle();
    mode_wr = 1'b1; mode_wdata = 2'b10; pll_wr = 1'b1; pll_wdata = 2'b00;
    step();
    mode_wr = 1'b0; pll_wr = 1'b0;
    chk("R3 write ignored req", mode_req, 0);
    chk("R3 write ignored state", lpm_state, 1);
    chk("R10 pll write ignored", pll_pwr_en, 1);
    pulse_rtc();
    chk("R7 rtc wakes idle", lpm_state, 0);

    // R5/R6/R9: sleep with 11 request (sleep priority)
    write_mode(2'b11);
    chk("R2 sleep priority", mode_req, 2);
    step();
    chk("R5 sleep state", lpm_state, 2);
    chk("R5 sleep outs", outs(), exp_outs(0, 0, 1, 0, 1, 0, 0, 1));
    step();
    chk("R6 pulse ends", outs(), exp_outs(0, 0, 1, 0, 1, 0, 0, 0));
    irq = '1;
    step();
    irq = '0;
    chk("R7 masked irqs keep sleep", lpm_state, 2);
    wake_from_sleep(0, 0);
    chk("R10 pll stays off", pll_pwr_en, 0);
    write_pll(2'b11);
    chk("R10 pll reconnect", {pll_pwr_en, pll_connect}, 3);

    // R11: wake in the entry cycle, idle then sleep
    irq_mask = 8'h01;
    write_mode(2'b01);
    irq = 8'h01;
    step();
    irq = '0;
    chk("R11 idle entered anyway", lpm_state, 1);
    step();
    chk("R11 idle left next", lpm_state, 0);
    write_mode(2'b10);
    rtc_irq = 1'b1;
    step();
    rtc_irq = 1'b0;
    chk("R11 sleep entered anyway", lpm_state, 2);
    chk("R6 pulse on entry", cpu_div_clr, 1);
    step();
    chk("R11 sleep left next", lpm_state, 3);
    for (int k = 0; k < RC_SETTLE; k++) step();
    chk("R11 back in run", lpm_state, 0);
    chk("R6 no pulse outside entry", {cpu_div_clr, usb_div_clr}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule